// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into two request lines, one for high priority and one for low priority. It watches five sources. Three are external pins, each detected on an edge whose polarity software selects. One is a rollover of an external timer counter, in either 8-bit or 16-bit mode. The last is any change on a 4-bit port nibble.

Every source owns a sticky flag. Hardware only ever sets a flag, and software clears it by writing a one to its bit. Each source also has an enable bit. Every source except external pin 0 has a priority bit; pin 0 is always routed to the high line. A master enable gates both request lines, and a second low-level enable also gates the low line. A wake output goes high as soon as any enabled external pin flag is set. It does not depend on the master enable, so a sleeping core can be woken with requests still masked.

Software reaches the block through a plain register port. A write is taken on the clock edge on which the write strobe is high. A read is combinational from the address. There is no back-pressure: every write is accepted in the cycle it is presented, and the read data is valid in the same cycle as the address.

Top module: `irq_ctrl_top`

## Requirements
- R1: External pin i is detected on a rising edge when its polarity bit (CTRL bit 3+i, address 0) is 1, and on a falling edge when that bit is 0. The pin passes through two synchronizer flops and an edge stage, so its flag (FLAG bit i, address 3) reads as set after the third rising clock edge that follows the pin change, and not earlier.
- R2: A detected event sets its flag even when the source's enable bit (EN address 1: bits 0-2 for the pins, bit 3 for the timer, bit 4 for the change source) is 0. With the enable at 0, that flag raises no request and no wake.
- R3: Flags are sticky. Writing a 1 to a bit of FLAG clears that flag. Writing a 0 to a bit leaves it unchanged. Hardware never clears a flag.
- R4: The wake output is high whenever some external pin has both its flag and its enable set, whatever the state of the master enable (CTRL bit 0).
- R5: irq_hi is high exactly when CTRL bit 0 is 1 and some source has its flag, its enable and high priority all set. High priority means PRIO bit = 1 (address 2: bit 1 for pin 1, bit 2 for pin 2, bit 3 for the timer, bit 4 for the change source). Pin 0 is always high priority, and PRIO bit 0 always reads 1.
- R6: irq_lo is high exactly when CTRL bit 0 and CTRL bit 1 are both 1 and some source has its flag and its enable set with low priority (PRIO bit = 0).
- R7: The timer flag (bit 3) is set when tmr_cnt changes from one cycle to the next in a rollover, and it is set on the edge after the rolled-over value is presented. With CTRL bit 2 = 0 the rollover is the low byte going from FFh to 00h. With CTRL bit 2 = 1 it is the whole 16-bit value going from FFFFh to 0000h.
- R8: Any change on the 4-bit port_hi input sets the change flag (bit 4), after the third clock edge, by the same timing as R1.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: After reset, CTRL reads 38h (all polarities rising, every enable and mode bit 0), EN reads 00h, PRIO reads 01h, FLAG reads 00h, and irq_hi, irq_lo and wake are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| port_hi | input | 4 | Monitored port nibble, asynchronous |
| tmr_cnt | input | 16 | Timer counter value, in the clk domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 EN, 2 PRIO, 3 FLAG |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wake-up from sleep or idle |

## Verification
Each result is due after a fixed number of edges. A pin or nibble change shows in FLAG after exactly three rising edges. A timer rollover shows one edge after the rolled-over count is presented. A register write takes effect on its own edge. The request lines, wake and read data follow the registers without delay. The bench applies each stimulus just after an edge, counts the required edges, and samples one time unit later. For pin 0 it also samples after only two edges, so that a flag arriving early would be caught. The set-over-clear race is produced by presenting the timer rollover in the same cycle as the clearing write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  localparam int CTRL_GLB     = 0;
  localparam int CTRL_LOGLB   = 1;
  localparam int CTRL_T16     = 2;
  localparam int CTRL_POL_LSB = 3;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int EXT_PINS = 3,
  parameter int CHG_BITS = 4,
  parameter int TMR_W    = 16,
  localparam int NSRC    = EXT_PINS + 2,
  localparam int HALF_W  = TMR_W / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EXT_PINS-1:0] pin_s,
  input  logic [EXT_PINS-1:0] pol,
  input  logic [CHG_BITS-1:0] chg_s,
  input  logic [TMR_W-1:0]    tmr_cnt,
  input  logic                tmr16,
  output logic [NSRC-1:0]     set_vec
);
  logic [EXT_PINS-1:0] pin_d;
  logic [CHG_BITS-1:0] chg_d;
  logic [TMR_W-1:0]    tmr_d;
  logic                roll8, roll16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d <= '0;
      chg_d <= '0;
      tmr_d <= '0;
    end else begin
      pin_d <= pin_s;
      chg_d <= chg_s;
      tmr_d <= tmr_cnt;
    end
  end

  for (genvar gi = 0; gi < EXT_PINS; gi++) begin : g_edge
    always_comb begin
      if (pol[gi]) set_vec[gi] = pin_s[gi] & ~pin_d[gi];
      else         set_vec[gi] = ~pin_s[gi] & pin_d[gi];
    end
  end

  assign roll8  = (&tmr_d[HALF_W-1:0]) & ~(|tmr_cnt[HALF_W-1:0]);
  assign roll16 = (&tmr_d) & ~(|tmr_cnt);

  assign set_vec[EXT_PINS]   = tmr16 ? roll16 : roll8;
  assign set_vec[EXT_PINS+1] = |(chg_s ^ chg_d);
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_ctrl_pkg::*;
#(
  parameter int EXT_PINS = 3,
  parameter int DW       = 8,
  parameter int ADDR_W   = 2,
  localparam int NSRC    = EXT_PINS + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic [NSRC-1:0]     set_vec,
  output logic                glb,
  output logic                lo_glb,
  output logic                tmr16,
  output logic [EXT_PINS-1:0] pol,
  output logic [NSRC-1:0]     en,
  output logic [NSRC-1:0]     prio_hi,
  output logic [NSRC-1:0]     flags
);
  logic [NSRC-1:1] prio_q;
  logic [NSRC-1:0] clr;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_addr[1:0]);
  assign clr = (reg_we && sel == SEL_FLAG) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb    <= 1'b0;
      lo_glb <= 1'b0;
      tmr16  <= 1'b0;
      pol    <= '1;
      en     <= '0;
      prio_q <= '0;
      flags  <= '0;
    end else begin
      if (reg_we && sel == SEL_CTRL) begin
        glb    <= reg_wdata[CTRL_GLB];
        lo_glb <= reg_wdata[CTRL_LOGLB];
        tmr16  <= reg_wdata[CTRL_T16];
        pol    <= reg_wdata[CTRL_POL_LSB +: EXT_PINS];
      end
      if (reg_we && sel == SEL_EN)   en     <= reg_wdata[NSRC-1:0];
      if (reg_we && sel == SEL_PRIO) prio_q <= reg_wdata[NSRC-1:1];
      flags <= (flags & ~clr) | set_vec;
    end
  end

  assign prio_hi = {prio_q, 1'b1};

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_GLB]                  = glb;
        reg_rdata[CTRL_LOGLB]                = lo_glb;
        reg_rdata[CTRL_T16]                  = tmr16;
        reg_rdata[CTRL_POL_LSB +: EXT_PINS]  = pol;
      end
      SEL_EN:   reg_rdata[NSRC-1:0] = en;
      SEL_PRIO: reg_rdata[NSRC-1:0] = prio_hi;
      SEL_FLAG: reg_rdata[NSRC-1:0] = flags;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int EXT_PINS = 3,
  parameter int CHG_BITS = 4,
  parameter int TMR_W    = 16,
  parameter int DW       = 8,
  parameter int ADDR_W   = 2,
  localparam int NSRC    = EXT_PINS + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EXT_PINS-1:0] ext_pin,
  input  logic [CHG_BITS-1:0] port_hi,
  input  logic [TMR_W-1:0]    tmr_cnt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq_hi,
  output logic                irq_lo,
  output logic                wake
);
  logic [EXT_PINS-1:0] pin_s, pol_w;
  logic [CHG_BITS-1:0] chg_s;
  logic [NSRC-1:0]     set_w, en_w, prio_w, flag_w, act_w;
  logic                glb_w, lo_glb_w, t16_w;

  irq_sync2 #(.W(EXT_PINS)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s)
  );

  irq_sync2 #(.W(CHG_BITS)) u_chg_sync (
    .clk(clk), .rst_n(rst_n), .d(port_hi), .q(chg_s)
  );

  irq_event_detect #(
    .EXT_PINS(EXT_PINS), .CHG_BITS(CHG_BITS), .TMR_W(TMR_W)
  ) u_evt (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pol(pol_w), .chg_s(chg_s),
    .tmr_cnt(tmr_cnt), .tmr16(t16_w), .set_vec(set_w)
  );

  irq_reg_file #(
    .EXT_PINS(EXT_PINS), .DW(DW), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_vec(set_w),
    .glb(glb_w), .lo_glb(lo_glb_w), .tmr16(t16_w), .pol(pol_w),
    .en(en_w), .prio_hi(prio_w), .flags(flag_w)
  );

  assign act_w = flag_w & en_w;

  always_comb begin
    irq_hi = glb_w & (|(act_w & prio_w));
    irq_lo = glb_w & lo_glb_w & (|(act_w & ~prio_w));
    wake   = |act_w[EXT_PINS-1:0];
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int EXT_PINS = 3,
  parameter int ADDR_W   = 2,
  parameter int DW       = 8,
  localparam int NSRC    = EXT_PINS + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic              wake,
  input logic [NSRC-1:0]   flag_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   set_vec,
  input logic              glb,
  input logic              lo_glb
);
  logic [NSRC-1:0] clr_m;
  assign clr_m = (reg_we && reg_addr == ADDR_W'(3)) ? reg_wdata[NSRC-1:0] : '0;

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flag_q) & ~$past(clr_m)) & ~flag_q) == '0));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~flag_q) == '0));

  p_wake_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((flag_q[EXT_PINS-1:0] & en_q[EXT_PINS-1:0]) != '0));

  p_hi_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |-> !irq_hi);

  p_pin0_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (glb && flag_q[0] && en_q[0]) |-> irq_hi);

  p_lo_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb && lo_glb) |-> !irq_lo);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
  .EXT_PINS(EXT_PINS), .ADDR_W(ADDR_W), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake),
  .flag_q(flag_w), .en_q(en_w), .set_vec(set_w), .glb(glb_w),
  .lo_glb(lo_glb_w)
);

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_pin = '0;
  logic [3:0]  port_hi = '0;
  logic [15:0] tmr_cnt = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_hi, irq_lo, wake;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_hi(port_hi),
    .tmr_cnt(tmr_cnt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_hi(irq_hi),
    .irq_lo(irq_lo), .wake(wake)
  );

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] en;
    logic [7:0] prio;
    logic       hi;
    logic       lo;
    logic       wk;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h38, 8'h1F, 8'h1E, 1'b0, 1'b0, 1'b1},
    '{8'h39, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'h3B, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0},
    '{8'h3B, 8'h10, 8'h10, 1'b1, 1'b0, 1'b0},
    '{8'h3B, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1},
    '{8'h3B, 8'h02, 8'h00, 1'b0, 1'b1, 1'b1},
    '{8'h3B, 8'h0C, 8'h04, 1'b1, 1'b1, 1'b1},
    '{8'h3B, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R10 reset state
    rd_check("R10 ctrl", 2'd0, 8'h38);
    rd_check("R10 en", 2'd1, 8'h00);
    rd_check("R10 prio", 2'd2, 8'h01);
    rd_check("R10 flag", 2'd3, 8'h00);
    check("R10 outputs", {13'd0, irq_hi, irq_lo, wake}, 16'd0);

    // R1 rising edge, three-edge latency
    ext_pin[0] = 1'b1;
    edges(2);
    rd_check("R1 early", 2'd3, 8'h00);
    edges(1);
    rd_check("R1 rise", 2'd3, 8'h01);
    wr(2'd3, 8'h01);
    ext_pin[0] = 1'b0;
    edges(3);
    rd_check("R1 fall ignored", 2'd3, 8'h00);
    wr(2'd0, 8'h30);
    ext_pin[0] = 1'b1;
    edges(3);
    rd_check("R1 rise ignored", 2'd3, 8'h00);
    ext_pin[0] = 1'b0;
    edges(3);
    rd_check("R1 fall", 2'd3, 8'h01);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h3B);

    // R2 flag set while disabled
    ext_pin[1] = 1'b1;
    edges(3);
    rd_check("R2 flag", 2'd3, 8'h02);
    check("R2 no req", {13'd0, irq_hi, irq_lo, wake}, 16'd0);
    wr(2'd1, 8'h02);
    check("R6 low req", {14'd0, irq_hi, irq_lo}, 16'd1);
    check("R4 wake", {15'd0, wake}, 16'd1);
    wr(2'd1, 8'h00);

    // R3 sticky, write-one-to-clear
    wr(2'd3, 8'h00);
    edges(4);
    rd_check("R3 zero write", 2'd3, 8'h02);
    wr(2'd3, 8'h02);
    rd_check("R3 clear", 2'd3, 8'h00);

    // R7 timer rollover modes
    tmr_cnt = 16'h12FF; edges(1);
    tmr_cnt = 16'h1300; edges(1);
    rd_check("R7 8-bit", 2'd3, 8'h08);
    wr(2'd3, 8'h08);
    wr(2'd0, 8'h3F);
    tmr_cnt = 16'h12FF; edges(1);
    tmr_cnt = 16'h1300; edges(1);
    rd_check("R7 16-bit low byte only", 2'd3, 8'h00);
    tmr_cnt = 16'hFFFF; edges(1);
    tmr_cnt = 16'h0000; edges(1);
    rd_check("R7 16-bit", 2'd3, 8'h08);

    // R9 set beats clear
    tmr_cnt = 16'hFFFF; edges(1);
    tmr_cnt = 16'h0000;
    wr(2'd3, 8'h08);
    rd_check("R9 set wins", 2'd3, 8'h08);
    wr(2'd3, 8'h08);
    rd_check("R9 plain clear", 2'd3, 8'h00);
    wr(2'd0, 8'h3B);

    // R8 change detect both ways
    port_hi = 4'b0100;
    edges(3);
    rd_check("R8 change up", 2'd3, 8'h10);
    wr(2'd3, 8'h10);
    port_hi = 4'b0000;
    edges(3);
    rd_check("R8 change down", 2'd3, 8'h10);
    wr(2'd3, 8'h10);

    // set every flag for the routing table
    ext_pin = 3'b000; edges(3);
    ext_pin = 3'b111; edges(3);
    tmr_cnt = 16'h00FF; edges(1);
    tmr_cnt = 16'h0000; edges(1);
    port_hi = 4'b0001; edges(3);
    rd_check("R2 all flags", 2'd3, 8'h1F);

    // R4 R5 R6 routing table
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, VECS[i].ctrl);
      wr(2'd1, VECS[i].en);
      wr(2'd2, VECS[i].prio);
      check($sformatf("R5 hi row %0d", i), {15'd0, irq_hi}, {15'd0, VECS[i].hi});
      check($sformatf("R6 lo row %0d", i), {15'd0, irq_lo}, {15'd0, VECS[i].lo});
      check($sformatf("R4 wake row %0d", i), {15'd0, wake}, {15'd0, VECS[i].wk});
    end
    rd_check("R5 prio bit0 fixed", 2'd2, 8'h01);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule